// File: doc/BRIEF.md
# Universal Serial Shift Unit

This block is a general-purpose serial shifter for software-driven serial links. It has a data register that shifts one bit per selected serial clock edge and a small edge counter that advances on every serial clock edge. When the counter wraps, it raises an overflow flag, which marks the end of a transfer. The serial clock comes from an external master. Both the serial clock and the data input pass through a two-flop synchronizer and are then edge-detected in the system clock domain.

A control register selects one of two modes. In three-wire mode, the unit acts as the data path of an SPI slave: the byte the host loads is shifted out MSB first, and the bits from the master fill the register from bit 0. In two-wire mode, the unit is only the physical layer of an open-drain clock/data bus. It shifts on falling edges and drives the data line low from the register's top bit. After an overflow it holds the clock line low, which stalls the master until software clears the flag. Software sets the counter through the status register, so a transfer can end after any number of edges from 1 to 16, for example 2 edges for an acknowledge bit.

Top module: `ushift_unit`

## Requirements
- R1: After reset, the data, status and control registers all read 0, and `sdo_out`, `scl_low_out` and `sda_low_out` are all 0.
- R2: A host write to address 0 loads the data register, and a write to address 2 loads control bits [3:0]. Both read back unchanged. Control bits [1:0] set the mode (01 three-wire, 10 two-wire, 00 and 11 off), bit 2 selects the three-wire shift edge (0 rising, 1 falling), and bit 3 enables the two-wire data driver.
- R3: In three-wire mode, each selected serial clock edge shifts the data register left by one place, and the synchronized data input enters bit 0. `sdo_out` always shows bit 7, so 8 shifts send the loaded byte MSB first and leave the received byte in the register.
- R4: In an active mode, every serial clock edge, rising or falling, adds one to the 4-bit counter (status bits [3:0]). A step from 15 to 0 sets the overflow flag (status bit 7), so 16 edges from a count of 0 complete one byte.
- R5: A status write loads the counter from bits [3:0]. It clears the overflow flag only when bit 7 is 1; with bit 7 at 0 the flag keeps its value.
- R6: Presetting the counter to 16 minus N ends the transfer after exactly N edges.
- R7: In two-wire mode, shifts happen only on falling serial clock edges, whatever the edge-select bit holds. Rising edges only advance the counter.
- R8: In two-wire mode, `scl_low_out` is 1 while the overflow flag is set. It returns to 0 once a status write clears the flag.
- R9: `sda_low_out` is 1 only in two-wire mode with the data driver enabled and bit 7 of the data register at 0.
- R10: With the mode off, serial clock edges neither shift the data register nor change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sclk_in | input | 1 | Serial clock from the master (line level) |
| sd_in | input | 1 | Serial data input (three-wire data in or two-wire data line level) |
| sdo_out | output | 1 | Three-wire serial data output (bit 7 of the data register) |
| scl_low_out | output | 1 | Pull the two-wire clock line low (clock hold) |
| sda_low_out | output | 1 | Pull the two-wire data line low |

## Verification
Two properties rely on the host not writing the status register in the same system cycle in which a serial edge wraps the counter. With such a write, the preset would override the wrap and the link between flag and counter would no longer hold. The synchronizers also assume that each serial clock level lasts at least three system cycles, so that no edge is lost. The stimulus holds every serial clock and data level for five system cycles. It changes the data input only while the clock is steady, and it makes register writes only between edges, after the previous edge has fully settled.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_THREE = 2'b01,
    MODE_TWO   = 2'b10,
    MODE_RSVD  = 2'b11
  } ushift_mode_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int CTRL_W      = 4;
  localparam int CTRL_EDGE   = 2;
  localparam int CTRL_SDA_EN = 3;

endpackage

// File: rtl/ushift_sync.sv
module ushift_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/ushift_edge.sv
module ushift_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

endmodule

// File: rtl/ushift_shreg.sv
module ushift_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  input  logic             sin,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_d;
  logic             q_en;

  always_comb begin
    q_en = load | shift;
    q_d  = q;
    if (load)       q_d = load_val;
    else if (shift) q_d = {q[WIDTH-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

endmodule

// File: rtl/ushift_counter.sv
module ushift_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             preset,
  input  logic [CNT_W-1:0] preset_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;
  logic             flag_d;
  logic             wrap;

  always_comb begin
    wrap  = step & (cnt == CNT_MAX);
    cnt_d = cnt;
    if (preset)    cnt_d = preset_val;
    else if (step) cnt_d = cnt + 1'b1;
    flag_d = flag;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      cnt  <= cnt_d;
      flag <= flag_d;
    end
  end

endmodule

// File: rtl/ushift_unit.sv
module ushift_unit
  import ushift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sclk_in,
  input  logic              sd_in,
  output logic              sdo_out,
  output logic              scl_low_out,
  output logic              sda_low_out
);

  localparam int STAT_PAD = DATA_W - 1 - CNT_W;
  localparam int CTRL_PAD = DATA_W - CTRL_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // host decode
  logic data_wr, stat_wr, ctrl_wr;
  assign data_wr = reg_wr & (reg_addr == ADDR_DATA);
  assign stat_wr = reg_wr & (reg_addr == ADDR_STAT);
  assign ctrl_wr = reg_wr & (reg_addr == ADDR_CTRL);

  // control register
  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = reg_wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ctrl_q <= '0;
    else            ctrl_q <= ctrl_d;
  end

  ushift_mode_e mode;
  logic         mode_three, mode_two, mode_active;
  assign mode        = ushift_mode_e'(ctrl_q[1:0]);
  assign mode_three  = (mode == MODE_THREE);
  assign mode_two    = (mode == MODE_TWO);
  assign mode_active = mode_three | mode_two;

  // input synchronization and edge detection
  logic [1:0] sync_out;
  logic       sclk_s, sd_s;
  logic       sclk_rise, sclk_fall;

  ushift_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  ({sclk_in, sd_in}),
    .dout (sync_out)
  );
  assign sclk_s = sync_out[1];
  assign sd_s   = sync_out[0];

  ushift_edge u_edge (
    .clk  (clk),
    .rst_n(rst_int_n),
    .level(sclk_s),
    .rise (sclk_rise),
    .fall (sclk_fall)
  );

  // shift and count enables
  logic shift_en, step_en;
  always_comb begin
    shift_en = 1'b0;
    if (mode_three)    shift_en = ctrl_q[CTRL_EDGE] ? sclk_fall : sclk_rise;
    else if (mode_two) shift_en = sclk_fall;
    step_en = mode_active & (sclk_rise | sclk_fall);
  end

  logic [DATA_W-1:0] data_q;

  ushift_shreg #(.WIDTH(DATA_W)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (data_wr),
    .load_val(reg_wdata),
    .shift   (shift_en),
    .sin     (sd_s),
    .q       (data_q)
  );

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  ushift_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .step      (step_en),
    .preset    (stat_wr),
    .preset_val(reg_wdata[CNT_W-1:0]),
    .flag_clr  (stat_wr & reg_wdata[DATA_W-1]),
    .cnt       (cnt_q),
    .flag      (flag_q)
  );

  // read mux
  always_comb begin
    unique case (reg_addr)
      ADDR_DATA: reg_rdata = data_q;
      ADDR_STAT: reg_rdata = {flag_q, {STAT_PAD{1'b0}}, cnt_q};
      ADDR_CTRL: reg_rdata = {{CTRL_PAD{1'b0}}, ctrl_q};
      default:   reg_rdata = '0;
    endcase
  end

  // pin drivers
  assign sdo_out     = mode_three & data_q[DATA_W-1];
  assign scl_low_out = mode_two & flag_q;
  assign sda_low_out = mode_two & ctrl_q[CTRL_SDA_EN] & ~data_q[DATA_W-1];

endmodule

// File: rtl/ushift_unit_chk.sv
module ushift_unit_chk
  import ushift_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] data_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              flag_q,
  input logic [3:0]        ctrl_q,
  input logic              scl_low_out,
  input logic              sda_low_out
);

  logic stat_wr, data_wr, ctrl_wr, clr_wr, mode_off;
  assign stat_wr  = reg_wr & (reg_addr == ADDR_STAT);
  assign data_wr  = reg_wr & (reg_addr == ADDR_DATA);
  assign ctrl_wr  = reg_wr & (reg_addr == ADDR_CTRL);
  assign clr_wr   = stat_wr & reg_wdata[DATA_W-1];
  assign mode_off = (ctrl_q[1:0] == MODE_OFF) || (ctrl_q[1:0] == MODE_RSVD);

  // R4: without a preset, the counter only moves up by one
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) && !$past(stat_wr) |-> cnt_q == $past(cnt_q) + 1'b1);

  // R4: the flag rises only out of a full counter
  p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cnt_q) == {CNT_W{1'b1}});

  // R5: the flag survives anything but a write-one clear
  p_flag_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_wr |=> flag_q);

  // R10: with the mode off, data and counter move only by host writes
  p_off_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off && !data_wr |=> $stable(data_q));

  p_off_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off && !stat_wr |=> $stable(cnt_q));

  // R8: the clock hold is released only by a clear or a mode change
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_low_out) |-> $past(clr_wr) || $past(ctrl_wr));

  // R9: the data line is pulled low only for a zero top bit in two-wire mode
  p_sda_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low_out |-> (ctrl_q[1:0] == MODE_TWO) && !data_q[DATA_W-1]);

endmodule

bind ushift_unit ushift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .data_q     (data_q),
  .cnt_q      (cnt_q),
  .flag_q     (flag_q),
  .ctrl_q     (ctrl_q),
  .scl_low_out(scl_low_out),
  .sda_low_out(sda_low_out)
);

// File: tb/ushift_unit_test.sv
module ushift_unit_test;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       sclk_in;
  logic       sd_in;
  logic       sdo_out;
  logic       scl_low_out;
  logic       sda_low_out;

  int checks;
  int errors;

  ushift_unit uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .sclk_in    (sclk_in),
    .sd_in      (sd_in),
    .sdo_out    (sdo_out),
    .scl_low_out(scl_low_out),
    .sda_low_out(sda_low_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_sim();
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic sclk(logic v);
    @(negedge clk);
    sclk_in = v;
    wait_cyc(5);
  endtask

  task automatic expect_reg(string req, logic [1:0] a, logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(req, v, e);
  endtask

  task automatic t_reset();
    expect_reg("R1 data", 2'd0, 8'h00);
    expect_reg("R1 status", 2'd1, 8'h00);
    expect_reg("R1 control", 2'd2, 8'h00);
    check("R1 pins", {5'b0, sdo_out, scl_low_out, sda_low_out}, 8'h00);
  endtask

  task automatic t_regs();
    wr(2'd2, 8'h0D);
    expect_reg("R2 control readback", 2'd2, 8'h0D);
    wr(2'd0, 8'hC3);
    expect_reg("R2 data readback", 2'd0, 8'hC3);
  endtask

  task automatic t_spi_byte();
    logic [7:0] tx = 8'hA5;
    logic [7:0] rx = 8'h3C;
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h80);
    wr(2'd0, tx);
    for (int i = 0; i < 8; i++) begin
      check("R3 sdo bit", {7'b0, sdo_out}, {7'b0, tx[7-i]});
      @(negedge clk); sd_in = rx[7-i];
      wait_cyc(3);
      sclk(1'b1);
      if (i == 7) expect_reg("R4 count 15 no flag", 2'd1, 8'h0F);
      sclk(1'b0);
      if (i == 2) expect_reg("R4 count after 3 bits", 2'd1, 8'h06);
    end
    expect_reg("R3 received byte", 2'd0, rx);
    expect_reg("R4 wrap sets flag", 2'd1, 8'h80);
  endtask

  task automatic t_neg_edge();
    wr(2'd2, 8'h05);
    wr(2'd1, 8'h80);
    wr(2'd0, 8'h81);
    @(negedge clk); sd_in = 1'b1;
    wait_cyc(3);
    sclk(1'b1);
    expect_reg("R3 rising ignored for falling select", 2'd0, 8'h81);
    sclk(1'b0);
    expect_reg("R3 falling edge shift", 2'd0, 8'h03);
    expect_reg("R4 both edges counted", 2'd1, 8'h02);
  endtask

  task automatic t_w1c();
    // flag is set from the byte transfer; counter is 0
    wr(2'd1, 8'h05);
    expect_reg("R5 write zero keeps flag, loads count", 2'd1, 8'h85);
    wr(2'd1, 8'h80);
    expect_reg("R5 write one clears flag", 2'd1, 8'h00);
  endtask

  task automatic t_preset();
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h8E);
    sclk(1'b1);
    expect_reg("R6 one edge left", 2'd1, 8'h0F);
    sclk(1'b0);
    expect_reg("R6 end after two edges", 2'd1, 8'h80);
    wr(2'd1, 8'h80);
  endtask

  task automatic t_two_wire();
    wr(2'd2, 8'h0E);
    wr(2'd1, 8'h8C);
    wr(2'd0, 8'h40);
    check("R9 sda low for zero top bit", {7'b0, sda_low_out}, 8'h01);
    @(negedge clk); sd_in = 1'b1;
    wait_cyc(3);
    sclk(1'b1);
    expect_reg("R7 no shift on rising", 2'd0, 8'h40);
    sclk(1'b0);
    expect_reg("R7 shift on falling", 2'd0, 8'h81);
    check("R9 sda released for one top bit", {7'b0, sda_low_out}, 8'h00);
    check("R8 no hold before wrap", {7'b0, scl_low_out}, 8'h00);
    sclk(1'b1);
    sclk(1'b0);
    expect_reg("R7 second falling shift", 2'd0, 8'h03);
    check("R8 hold after wrap", {7'b0, scl_low_out}, 8'h01);
    wait_cyc(10);
    check("R8 hold persists", {7'b0, scl_low_out}, 8'h01);
    wr(2'd1, 8'h80);
    wait_cyc(1);
    check("R8 release after clear", {7'b0, scl_low_out}, 8'h00);
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h00);
    check("R9 driver disabled", {7'b0, sda_low_out}, 8'h00);
  endtask

  task automatic t_off();
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'h83);
    sclk(1'b1);
    sclk(1'b0);
    expect_reg("R10 data unchanged when off", 2'd0, 8'h5A);
    expect_reg("R10 count unchanged when off", 2'd1, 8'h03);
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    sclk_in = 1'b0; sd_in = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_regs();
    t_spi_byte();
    t_w1c();
    t_neg_edge();
    t_preset();
    t_two_wire();
    t_off();
    finish_sim();
  end

endmodule